// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits on the CPU side of a system controller. It decides which programmable address window a CPU address falls into. Ten windows are kept in a small register bank: four for device chip selects and six for the PCI side, which has one I/O window and two memory windows on each of two ports. Every window is set by a start register and an end register, both counted in 2 MB units. Each window can also carry a second alias span, placed by its own remap register, that points back onto the primary span. A fixed 4 KB window, placed by a separate base register, selects the controller's own register space and wins over everything else.

Two fixed reserved holes, 0x1E000000 up to 0x1F100000 and 0x1FC00000 up to 0x1FD00000 (end exclusive), are trimmed out of every primary and alias span. Lookup is purely combinational. For each CPU address it returns a hit flag, the index of the winning window, whether the match was on an alias, and the translated target address. Register writes come through a single-cycle write strobe.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled (start register 0x007F, end register 0x00, remap register 0x07F, no alias armed), and the register-space window sits at base register 0x0DF, so 0x1BE00000 up to 0x1BE00FFF hits it and other addresses miss.
- R2: A write with `wr_en` high takes effect at the next clock edge. `wr_fld` selects the target: 0 is the start register of window `wr_win`, 1 its end register, 2 its remap register, and 3 the register-space base, for which `wr_win` is ignored. A field 0 to 2 write with `wr_win` of 10 or more changes nothing.
- R3: A window is enabled only when bits 6:0 of its 15-bit start register are no greater than its 7-bit end register. Its span starts at the start register times 2 MB, computed at 36-bit width. Its length is (end + 1 − start[6:0]) × 2 MB. A span above 4 GB never matches a 32-bit address.
- R4: Each span [begin, end) is trimmed in this order: an end inside hole 0 moves to its bottom; a begin inside hole 0 moves to its top; the same two steps for hole 1; then an end at or above a hole's top with a begin below that hole's bottom moves to that hole's bottom, hole 0 first. A span whose begin is not below its end matches nothing.
- R5: A start-register write also loads the window's 11-bit remap register from data bits 10:0 and disarms the alias. An end-register write disarms the alias. A remap-register write loads the remap register and arms the alias.
- R6: An armed alias of an enabled, non-empty window begins at the trimmed primary begin with address bits 31:21 replaced by the remap register. It has the same length as the trimmed primary, and it is then trimmed under R4 on its own.
- R7: On an alias hit, `lk_xaddr` is the lookup address minus the trimmed alias begin plus the trimmed primary begin (36 bits). On any other hit, and on a miss, `lk_xaddr` is the lookup address zero-extended.
- R8: The register-space window has priority over all others and reports `lk_internal` with `lk_win` = 10. Otherwise the lowest-numbered window whose primary or alias matches wins, and within that window the primary wins over the alias. On a miss, `lk_win` is 0.
- R9: The register-space window covers 4 KB starting at its 15-bit base register times 2 MB, computed at 36-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 4 | Window index for the write |
| wr_fld | input | 2 | Register select: 0 start, 1 end, 2 remap, 3 register-space base |
| wr_data | input | 15 | Write data |
| lk_addr | input | 32 | CPU address to decode |
| lk_hit | output | 1 | Address falls in some window |
| lk_internal | output | 1 | Hit is the register-space window |
| lk_alias | output | 1 | Hit is a window's alias span |
| lk_win | output | 4 | Winning window index, 10 for register space |
| lk_xaddr | output | 36 | Translated target address |

## Verification
The hardest states to reach are the ones that depend on write history rather than on the current register values: an alias armed, then disarmed by a rewrite of the end register with an unchanged value, and an alias armed on one window that lands on top of a higher-numbered primary. The stimulus reaches them through ordered write sequences, with a lookup after each step. Trimming is driven with windows whose begin falls inside a hole and windows that span a whole hole, and lookups are placed on both sides of every moved edge.

// File: rtl/awd_pkg.sv
package awd_pkg;

  // register select codes on the write port
  typedef enum logic [1:0] {
    FLD_LOW     = 2'd0,
    FLD_HIGH    = 2'd1,
    FLD_REMAP   = 2'd2,
    FLD_INTBASE = 2'd3
  } awd_fld_e;

  // reserved holes, end exclusive
  localparam longint unsigned HOLE0_BOT = 64'h0000_0000_1E00_0000;
  localparam longint unsigned HOLE0_TOP = 64'h0000_0000_1F10_0000;
  localparam longint unsigned HOLE1_BOT = 64'h0000_0000_1FC0_0000;
  localparam longint unsigned HOLE1_TOP = 64'h0000_0000_1FD0_0000;

endpackage

// File: rtl/awd_clip.sv
module awd_clip #(
  parameter int unsigned       XW  = 36,
  parameter longint unsigned   H0B = awd_pkg::HOLE0_BOT,
  parameter longint unsigned   H0T = awd_pkg::HOLE0_TOP,
  parameter longint unsigned   H1B = awd_pkg::HOLE1_BOT,
  parameter longint unsigned   H1T = awd_pkg::HOLE1_TOP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] in_beg,
  input  logic [XW:0]   in_end,
  output logic [XW-1:0] out_beg,
  output logic [XW:0]   out_end
);

  localparam logic [XW:0] B0 = (XW+1)'(H0B);
  localparam logic [XW:0] T0 = (XW+1)'(H0T);
  localparam logic [XW:0] B1 = (XW+1)'(H1B);
  localparam logic [XW:0] T1 = (XW+1)'(H1T);

  logic [XW-1:0] b;
  logic [XW:0]   e;

  // ordered trimming, each step sees the result of the previous one
  always_comb begin
    b = in_beg;
    e = in_end;
    if (e >= B0 && e < T0)                 e = B0;
    if ({1'b0, b} >= B0 && {1'b0, b} < T0) b = T0[XW-1:0];
    if (e >= B1 && e < T1)                 e = B1;
    if ({1'b0, b} >= B1 && {1'b0, b} < T1) b = T1[XW-1:0];
    if (e >= T0 && {1'b0, b} < B0)         e = B0;
    if (e >= T1 && {1'b0, b} < B1)         e = B1;
    out_beg = b;
    out_end = e;
  end

  // R4
  hole_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !({1'b0, out_beg} >= B0 && {1'b0, out_beg} < T0) &&
    !({1'b0, out_beg} >= B1 && {1'b0, out_beg} < T1) &&
    !(out_end > B0 && out_end < T0) && !(out_end > B1 && out_end < T1));

endmodule

// File: rtl/awd_win_slot.sv
module awd_win_slot
  import awd_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned GS     = 21,
  parameter int unsigned LO_W   = 15,
  parameter int unsigned HI_W   = 7,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned MY_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_win,
  input  awd_fld_e          wr_fld,
  input  logic [LO_W-1:0]   wr_data,
  input  logic [AW-1:0]     lk_addr,
  output logic              p_hit,
  output logic              a_hit,
  output logic [LO_W+GS-1:0] p_beg,
  output logic [LO_W+GS-1:0] a_beg
);

  localparam int unsigned EW    = LO_W + GS;
  localparam int unsigned RMP_W = AW - GS;
  localparam logic [LO_W-1:0]  LO_RST  = LO_W'({HI_W{1'b1}});
  localparam logic [RMP_W-1:0] RMP_RST = LO_RST[RMP_W-1:0];

  logic [LO_W-1:0]  lo_q,  lo_d;
  logic [HI_W-1:0]  hi_q,  hi_d;
  logic [RMP_W-1:0] rmp_q, rmp_d;
  logic             aok_q, aok_d;
  logic             sel, wr_ce;

  assign sel   = wr_en && (wr_win == IDX_W'(MY_IDX));
  assign wr_ce = sel && (wr_fld != FLD_INTBASE);

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    rmp_d = rmp_q;
    aok_d = aok_q;
    case (wr_fld)
      FLD_LOW: begin
        lo_d  = wr_data;
        rmp_d = wr_data[RMP_W-1:0];
        aok_d = 1'b0;
      end
      FLD_HIGH: begin
        hi_d  = wr_data[HI_W-1:0];
        aok_d = 1'b0;
      end
      FLD_REMAP: begin
        rmp_d = wr_data[RMP_W-1:0];
        aok_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= LO_RST;
      hi_q  <= '0;
      rmp_q <= RMP_RST;
      aok_q <= 1'b0;
    end else if (wr_ce) begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      rmp_q <= rmp_d;
      aok_q <= aok_d;
    end
  end

  // primary span
  logic          en;
  logic [HI_W:0] units;
  logic [EW-1:0] raw_beg, pb_c, ar_beg, ab_c;
  logic [EW:0]   raw_end, pe_c, p_len, ar_end, ae_c, lk_x;
  logic          p_live, a_live;

  assign en      = lo_q[HI_W-1:0] <= hi_q;
  assign units   = {1'b0, hi_q} + 1'b1 - {1'b0, lo_q[HI_W-1:0]};
  assign raw_beg = {lo_q, GS'(0)};
  assign raw_end = {1'b0, raw_beg} + ((EW+1)'(units) << GS);

  awd_clip #(.XW(EW)) u_pclip (
    .clk(clk), .rst_n(rst_n),
    .in_beg(raw_beg), .in_end(raw_end), .out_beg(pb_c), .out_end(pe_c)
  );

  assign p_live = en && (pe_c > {1'b0, pb_c});
  assign p_len  = pe_c - {1'b0, pb_c};

  // alias span: bits 31:21 from the remap register
  assign ar_beg = {pb_c[EW-1:AW], rmp_q, pb_c[GS-1:0]};
  assign ar_end = {1'b0, ar_beg} + p_len;

  awd_clip #(.XW(EW)) u_aclip (
    .clk(clk), .rst_n(rst_n),
    .in_beg(ar_beg), .in_end(ar_end), .out_beg(ab_c), .out_end(ae_c)
  );

  assign a_live = p_live && aok_q;
  assign lk_x   = (EW+1)'(lk_addr);
  assign p_hit  = en && ({1'b0, pb_c} <= lk_x) && (lk_x < pe_c);
  assign a_hit  = a_live && ({1'b0, ab_c} <= lk_x) && (lk_x < ae_c);
  assign p_beg  = pb_c;
  assign a_beg  = ab_c;

  // R5
  low_wr_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_fld == FLD_LOW) |=> (!aok_q && rmp_q == $past(wr_data[RMP_W-1:0])));
  // R5
  remap_wr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_fld == FLD_REMAP) |=> aok_q);
  // R2
  other_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(lo_q) && $stable(hi_q) && $stable(rmp_q) && $stable(aok_q)));

endmodule

// File: rtl/awd_pick.sv
module awd_pick #(
  parameter int unsigned N  = 10,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_hit,
  input  logic [N-1:0]  p_hit,
  input  logic [N-1:0]  a_hit,
  output logic          hit,
  output logic          is_int,
  output logic          is_alias,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit      = 1'b0;
    is_int   = 1'b0;
    is_alias = 1'b0;
    idx      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (p_hit[i] || a_hit[i]) begin
        hit      = 1'b1;
        is_alias = !p_hit[i];
        idx      = IW'(i);
      end
    end
    if (int_hit) begin
      hit      = 1'b1;
      is_int   = 1'b1;
      is_alias = 1'b0;
      idx      = IW'(N);
    end
  end

  // R8
  first_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_hit[0] && !int_hit) |-> (hit && idx == '0 && !is_alias));

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned GS       = 21,
  parameter int unsigned LO_W     = 15,
  parameter int unsigned HI_W     = 7,
  parameter int unsigned NUM_WIN  = 10,
  parameter int unsigned INT_SH   = 12,
  parameter int unsigned INT_RST  = 'h0DF,
  parameter int unsigned IDX_W    = $clog2(NUM_WIN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_win,
  input  logic [1:0]           wr_fld,
  input  logic [LO_W-1:0]      wr_data,
  input  logic [AW-1:0]        lk_addr,
  output logic                 lk_hit,
  output logic                 lk_internal,
  output logic                 lk_alias,
  output logic [IDX_W-1:0]     lk_win,
  output logic [LO_W+GS-1:0]   lk_xaddr
);

  localparam int unsigned EW = LO_W + GS;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  awd_fld_e fld;
  assign fld = awd_fld_e'(wr_fld);

  // register-space base
  logic [LO_W-1:0] ib_q;
  logic            ib_ce;

  assign ib_ce = wr_en && (fld == FLD_INTBASE);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   ib_q <= LO_W'(INT_RST);
    else if (ib_ce) ib_q <= wr_data;
  end

  logic [EW-1:0] lk_x;
  logic          int_hit;

  assign lk_x    = EW'(lk_addr);
  assign int_hit = lk_x[EW-1:INT_SH] == {ib_q, (GS-INT_SH)'(0)};

  // window slots
  logic [NUM_WIN-1:0] p_hit, a_hit;
  logic [EW-1:0]      p_beg [NUM_WIN];
  logic [EW-1:0]      a_beg [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_slot
    awd_win_slot #(
      .AW(AW), .GS(GS), .LO_W(LO_W), .HI_W(HI_W), .IDX_W(IDX_W), .MY_IDX(g)
    ) u_slot (
      .clk(clk), .rst_n(rst_i_n),
      .wr_en(wr_en), .wr_win(wr_win), .wr_fld(fld), .wr_data(wr_data),
      .lk_addr(lk_addr),
      .p_hit(p_hit[g]), .a_hit(a_hit[g]),
      .p_beg(p_beg[g]), .a_beg(a_beg[g])
    );
  end

  awd_pick #(.N(NUM_WIN), .IW(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_i_n),
    .int_hit(int_hit), .p_hit(p_hit), .a_hit(a_hit),
    .hit(lk_hit), .is_int(lk_internal), .is_alias(lk_alias), .idx(lk_win)
  );

  // translation for the winning alias
  logic [EW-1:0] sel_p, sel_a;

  always_comb begin
    sel_p = '0;
    sel_a = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (lk_win == IDX_W'(i)) begin
        sel_p = p_beg[i];
        sel_a = a_beg[i];
      end
    end
  end

  assign lk_xaddr = lk_alias ? (lk_x - sel_a + sel_p) : lk_x;

  // R9
  int_base_wr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ib_ce |=> (ib_q == $past(wr_data)));
  // R8
  int_wins_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    lk_internal |-> (lk_hit && !lk_alias && lk_win == IDX_W'(NUM_WIN)));
  // R7
  plain_xaddr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !lk_alias |-> (lk_xaddr == lk_x));

endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;

  localparam int NW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_win = '0;
  logic [1:0]  wr_fld = '0;
  logic [14:0] wr_data = '0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_internal, lk_alias;
  logic [3:0]  lk_win;
  logic [35:0] lk_xaddr;

  always #5 clk = ~clk;

  addr_window_decoder u_addr_window_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_fld(wr_fld),
    .wr_data(wr_data), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_internal(lk_internal), .lk_alias(lk_alias), .lk_win(lk_win),
    .lk_xaddr(lk_xaddr)
  );

  // requirement model
  logic [14:0] m_lo [NW];
  logic [6:0]  m_hi [NW];
  logic [10:0] m_rm [NW];
  logic        m_ok [NW];
  logic [14:0] m_ib;

  typedef struct {
    string       req;
    logic [31:0] a;
    logic        hit, intl, als;
    logic [3:0]  idx;
    logic [35:0] xa;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  localparam logic [63:0] B0 = 64'h1E00_0000, T0 = 64'h1F10_0000;
  localparam logic [63:0] B1 = 64'h1FC0_0000, T1 = 64'h1FD0_0000;

  // R4 trimming order
  function automatic void trim(inout logic [63:0] b, inout logic [63:0] e);
    if (e >= B0 && e < T0) e = B0;
    if (b >= B0 && b < T0) b = T0;
    if (e >= B1 && e < T1) e = B1;
    if (b >= B1 && b < T1) b = T1;
    if (e >= T0 && b < B0) e = B0;
    if (e >= T1 && b < B1) e = B1;
  endfunction

  function automatic exp_t predict(string req, logic [31:0] a);
    exp_t r;
    logic [63:0] aa, ib, b, e, ab, ae;
    aa = 64'(a);
    r.req = req; r.a = a; r.hit = 0; r.intl = 0; r.als = 0; r.idx = 0;
    r.xa = 36'(aa);
    ib = 64'(m_ib) << 21;
    if (aa >= ib && aa < ib + 64'd4096) begin       // R9, R8
      r.hit = 1; r.intl = 1; r.idx = 4'(NW);
      return r;
    end
    for (int i = 0; i < NW; i++) begin
      if (64'(m_lo[i][6:0]) <= 64'(m_hi[i])) begin  // R3
        b = 64'(m_lo[i]) << 21;
        e = b + ((64'(m_hi[i]) + 64'd1 - 64'(m_lo[i][6:0])) << 21);
        trim(b, e);
        if (b <= aa && aa < e) begin
          r.hit = 1; r.idx = 4'(i);
          return r;
        end
        if (m_ok[i] && e > b) begin                 // R6
          ab = (b & ~(64'h7FF << 21)) | (64'(m_rm[i]) << 21);
          ae = ab + (e - b);
          trim(ab, ae);
          if (ab <= aa && aa < ae) begin
            r.hit = 1; r.als = 1; r.idx = 4'(i);
            r.xa = 36'(aa - ab + b);                // R7
            return r;
          end
        end
      end
    end
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NW; i++) begin
      m_lo[i] = 15'h007F; m_hi[i] = '0; m_rm[i] = 11'h07F; m_ok[i] = 0;
    end
    m_ib = 15'h00DF;
  endtask

  task automatic wr(input int win, input int fld, input logic [14:0] d);
    @(negedge clk);
    wr_en = 1; wr_win = 4'(win); wr_fld = 2'(fld); wr_data = d;
    if (fld == 3) m_ib = d;
    else if (win < NW) begin
      case (fld)
        0: begin m_lo[win] = d; m_rm[win] = d[10:0]; m_ok[win] = 0; end
        1: begin m_hi[win] = d[6:0]; m_ok[win] = 0; end
        default: begin m_rm[win] = d[10:0]; m_ok[win] = 1; end
      endcase
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input string req, input logic [31:0] a);
    @(negedge clk);
    lk_addr = a;
    q.push_back(predict(req, a));
  endtask

  // monitor: compare away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_internal !== e.intl || lk_alias !== e.als ||
            lk_win !== e.idx || lk_xaddr !== e.xa) begin
          fails++;
          $display("FAIL %s addr=%h actual hit=%b int=%b als=%b win=%0d xa=%h expected hit=%b int=%b als=%b win=%0d xa=%h",
                   e.req, e.a, lk_hit, lk_internal, lk_alias, lk_win, lk_xaddr,
                   e.hit, e.intl, e.als, e.idx, e.xa);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    look("R1", 32'h1BE0_0010);
    look("R1", 32'h1BE0_1000);
    look("R1", 32'h0010_0000);

    // R3 primary span, R2 write timing
    wr(0, 0, 15'h0000);
    wr(0, 1, 15'h0003);
    look("R3", 32'h0012_3456);
    look("R3", 32'h007F_FFFF);
    look("R3", 32'h0080_0000);
    wr(1, 0, 15'h0005);
    wr(1, 1, 15'h0004);
    look("R3", 32'h00A0_0000);
    wr(1, 1, 15'h0005);
    look("R3", 32'h00A0_0000);
    look("R3", 32'h00C0_0000);

    // R8 overlap, lower index wins
    wr(2, 0, 15'h0000);
    wr(2, 1, 15'h0001);
    look("R8", 32'h0010_0000);

    // R4 begin inside hole 0
    wr(3, 0, 15'h00F0);
    wr(3, 1, 15'h00F9);
    look("R4", 32'h1E10_0000);
    look("R4", 32'h1F10_0000);
    look("R4", 32'h1F3F_FFFF);
    // R4 window spanning both holes
    wr(4, 0, 15'h00E0);
    wr(4, 1, 15'h00FF);
    look("R4", 32'h1DFF_FFFF);
    look("R4", 32'h1E00_0000);
    look("R4", 32'h1FE0_0000);

    // R6 / R7 alias on window 0
    wr(0, 2, 15'h0010);
    look("R6", 32'h0234_5678);
    look("R7", 32'h027F_FFFC);
    look("R6", 32'h0280_0000);
    // R5 end write with unchanged value disarms
    wr(0, 1, 15'h0003);
    look("R5", 32'h0234_5678);

    // R5 start write loads remap but leaves alias off
    wr(5, 0, 15'h0040);
    wr(5, 1, 15'h0040);
    look("R5", 32'h0800_0010);
    wr(5, 2, 15'h0050);
    look("R7", 32'h0A00_0010);
    wr(5, 0, 15'h0040);
    look("R5", 32'h0A00_0010);

    // R8 alias of window 6 over primary of window 7
    wr(7, 0, 15'h0060);
    wr(7, 1, 15'h0060);
    wr(6, 0, 15'h0070);
    wr(6, 1, 15'h0070);
    look("R8", 32'h0C00_0004);
    wr(6, 2, 15'h0060);
    look("R8", 32'h0C00_0004);

    // R3 start register above 4 GB never matches
    wr(8, 0, 15'h7850);
    wr(8, 1, 15'h0050);
    look("R3", 32'h0A00_0000);

    // R2 out-of-range window index ignored
    wr(12, 0, 15'h0000);
    wr(12, 1, 15'h007F);
    look("R2", 32'h0C00_0004);
    look("R2", 32'h0F00_0000);

    // R9 register-space window moved onto window 0
    wr(0, 3, 15'h0000);
    look("R9", 32'h0000_0010);
    look("R9", 32'h0000_1000);
    look("R9", 32'h1BE0_0010);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule